// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Window Sequencer

This block places one address window per serial-flash chip select on the system bus and turns each bus access into a complete flash command frame. An access names a chip select, an offset inside that chip's 128 MiB window, a length of one to eight bytes (unaligned offsets allowed), and a direction. The sequencer selects the chip, sends the command byte for that direction, the address, then (on reads only) a run of dummy transfers. It then moves the data bytes and releases the chip.

Framing is taken from two static configuration words, one for reads and one for writes. Each holds a command code, an address-length code and, for reads, a dummy-length field and an access-width field that together set the dummy count. Bytes move through an external byte-wide shifter over a request/acknowledge handshake. The bus sees one ready pulse per access, in the cycle the chip select is released, with read data valid in that cycle. If a software-driven transfer is already holding a chip select when an access is taken, the access still runs but is marked with an error flag.

Top module: `flash_window_seq`

## Requirements
- R1: After reset every `cs_n` line is high, `sh_req` is low and `bus_ready` is low, and all three stay that way while no access is in progress.
- R2: For an accepted access exactly one `cs_n` line goes low, the one numbered by `bus_cs_sel`. It goes low before the first shifter request and stays low for every transfer of the frame.
- R3: The first transfer of a frame is the command byte, taken from bits 7:0 of `rd_cfg` on a read (`bus_we`=0) and from bits 7:0 of `wr_cfg` on a write (`bus_we`=1).
- R4: Bits 17:16 of the active config word select the address length: code 0 sends 3 bytes and code 1 sends 4 bytes, most significant byte first, from the window offset zero-extended to 32 bits.
- R5: Address-length codes 2 and 3 send no address bytes, and the frame continues with the next phase.
- R6: A read sends (`rd_cfg`[13:12] × 8) >> `rd_cfg`[9:8] dummy transfers after the address, each with a transmit byte of 0x00. A write sends none.
- R7: Read data: `bus_size` holds the byte count minus one. Received byte i (counting from 0) goes to `bus_rdata` bits 8i+7:8i, and lanes beyond the count read as zero. During read data transfers the transmit byte is 0x00.
- R8: Write data: byte count is `bus_size`+1, and byte i sent is `bus_wdata` bits 8i+7:8i, lowest lane first.
- R9: `bus_ready` is a one-cycle pulse in the first cycle after the last data transfer. In that cycle all `cs_n` lines are high and `bus_rdata` holds the result.
- R10: If `uma_cs_busy` is high when an access is accepted, `bus_err` is high together with `bus_ready` and the frame still runs in full. Otherwise `bus_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cs_sel | input | CS_W | Chip select (window) number |
| bus_addr | input | WIN_AW | Byte offset inside the window |
| bus_size | input | SZ_W | Byte count minus one |
| bus_wdata | input | 8*MAX_BYTES | Write data, lane 0 sent first |
| bus_rdata | output | 8*MAX_BYTES | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access complete pulse |
| bus_err | output | 1 | Access overlapped a held chip select |
| rd_cfg | input | 32 | Read framing word |
| wr_cfg | input | 32 | Write framing word |
| uma_cs_busy | input | 1 | A software transfer holds a chip select |
| cs_n | output | NUM_CS | Active-low chip selects |
| sh_req | output | 1 | Shifter byte request |
| sh_tx | output | 8 | Byte to shift out |
| sh_ack | input | 1 | Shifter byte done pulse |
| sh_rx | input | 8 | Byte shifted in, valid with `sh_ack` |

## Verification
A corrupted phase or counter shows up at the shifter port as a wrong transfer count or a wrong byte at a fixed position in the frame, and this happens within the frame that triggered it. A wrong chip-select register shows as a second low line, or as a line that is low outside a frame, in the very cycle it happens. A data-lane indexing error appears as swapped bytes in `bus_rdata` at the next ready pulse, or as swapped bytes on `sh_tx` during the data phase.

// File: rtl/fws_pkg.sv
package fws_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CMD   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DUMMY = 3'd3,
        PH_DATA  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    // address-length codes held in config bits 17:16
    localparam logic [1:0] ALEN_THREE = 2'd0;
    localparam logic [1:0] ALEN_FOUR  = 2'd1;

    typedef struct packed {
        logic [7:0] cmd;
        logic [2:0] n_addr;
        logic [4:0] n_dummy;
    } frame_plan_t;

endpackage

// File: rtl/fws_plan_decode.sv
module fws_plan_decode
    import fws_pkg::*;
(
    input  logic [31:0]  cfg,
    input  logic         is_read,
    output frame_plan_t  plan
);
    logic [4:0] raw_dummy;
    logic       unused_cfg;

    assign unused_cfg = ^{cfg[31:18], cfg[15:14], cfg[11:10]};

    always_comb begin
        plan.cmd = cfg[7:0];
        case (cfg[17:16])
            ALEN_THREE: plan.n_addr = 3'd3;
            ALEN_FOUR:  plan.n_addr = 3'd4;
            default:    plan.n_addr = 3'd0;
        endcase
        raw_dummy    = {cfg[13:12], 3'b000};
        plan.n_dummy = is_read ? (raw_dummy >> cfg[9:8]) : 5'd0;
    end
endmodule

// File: rtl/fws_cs_decode.sv
module fws_cs_decode #(
    parameter int NUM_CS = 2,
    parameter int CS_W   = 1
) (
    input  logic [CS_W-1:0]   sel,
    output logic [NUM_CS-1:0] onehot
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign onehot[i] = (sel == CS_W'(i));
    end
endmodule

// File: rtl/fws_tx_mux.sv
module fws_tx_mux
    import fws_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int SZ_W      = 3
) (
    input  phase_e                 phase,
    input  logic [SZ_W-1:0]        lane,
    input  logic [1:0]             addr_pos,
    input  logic [7:0]             cmd,
    input  logic [31:0]            addr,
    input  logic [2:0]             n_addr,
    input  logic                   we,
    input  logic [8*MAX_BYTES-1:0] wdata,
    output logic [7:0]             tx
);
    logic [2:0] addr_idx;

    always_comb begin
        addr_idx = n_addr - 3'd1 - {1'b0, addr_pos};
        case (phase)
            PH_CMD:  tx = cmd;
            PH_ADDR: tx = addr[{addr_idx[1:0], 3'b000} +: 8];
            PH_DATA: tx = we ? wdata[{lane, 3'b000} +: 8] : 8'h00;
            default: tx = 8'h00;
        endcase
    end
endmodule

// File: rtl/flash_window_seq.sv
module flash_window_seq
    import fws_pkg::*;
#(
    parameter int NUM_CS    = 2,
    parameter int WIN_AW    = 27,
    parameter int MAX_BYTES = 8,
    parameter int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    parameter int SZ_W      = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req,
    input  logic                   bus_we,
    input  logic [CS_W-1:0]        bus_cs_sel,
    input  logic [WIN_AW-1:0]      bus_addr,
    input  logic [SZ_W-1:0]        bus_size,
    input  logic [8*MAX_BYTES-1:0] bus_wdata,
    output logic [8*MAX_BYTES-1:0] bus_rdata,
    output logic                   bus_ready,
    output logic                   bus_err,
    input  logic [31:0]            rd_cfg,
    input  logic [31:0]            wr_cfg,
    input  logic                   uma_cs_busy,
    output logic [NUM_CS-1:0]      cs_n,
    output logic                   sh_req,
    output logic [7:0]             sh_tx,
    input  logic                   sh_ack,
    input  logic [7:0]             sh_rx
);
    localparam int DATA_W = 8 * MAX_BYTES;
    localparam int CNT_W  = (SZ_W > 5) ? SZ_W : 5;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [NUM_CS-1:0]   cs;
        logic                we;
        logic [31:0]         addr;
        logic [SZ_W-1:0]     last;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        frame_plan_t         plan;
        logic                err;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    frame_plan_t       plan_new;
    logic [NUM_CS-1:0] sel_onehot;
    logic [31:0]       cfg_pick;
    phase_e            after_addr;
    phase_e            after_cmd;
    logic              unused_cnt;

    assign cfg_pick = bus_we ? wr_cfg : rd_cfg;

    fws_plan_decode u_plan (
        .cfg     (cfg_pick),
        .is_read (!bus_we),
        .plan    (plan_new)
    );

    fws_cs_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_csdec (
        .sel    (bus_cs_sel),
        .onehot (sel_onehot)
    );

    fws_tx_mux #(.MAX_BYTES(MAX_BYTES), .SZ_W(SZ_W)) u_tx (
        .phase    (st_q.phase),
        .lane     (st_q.cnt[SZ_W-1:0]),
        .addr_pos (st_q.cnt[1:0]),
        .cmd      (st_q.plan.cmd),
        .addr     (st_q.addr),
        .n_addr   (st_q.plan.n_addr),
        .we       (st_q.we),
        .wdata    (st_q.wdata),
        .tx       (sh_tx)
    );

    assign unused_cnt = ^st_q.cnt;

    always_comb begin
        after_addr = (st_q.plan.n_dummy != 5'd0) ? PH_DUMMY : PH_DATA;
        after_cmd  = (st_q.plan.n_addr != 3'd0) ? PH_ADDR : after_addr;
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (bus_req) begin
                    st_d.phase = PH_CMD;
                    st_d.cnt   = '0;
                    st_d.cs    = sel_onehot;
                    st_d.we    = bus_we;
                    st_d.addr  = 32'(bus_addr);
                    st_d.last  = bus_size;
                    st_d.wdata = bus_wdata;
                    st_d.rdata = '0;
                    st_d.plan  = plan_new;
                    st_d.err   = uma_cs_busy;
                end
            end
            PH_CMD: begin
                if (sh_ack) begin
                    st_d.phase = after_cmd;
                    st_d.cnt   = '0;
                end
            end
            PH_ADDR: begin
                if (sh_ack) begin
                    if (st_q.cnt == CNT_W'(st_q.plan.n_addr - 3'd1)) begin
                        st_d.phase = after_addr;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_DUMMY: begin
                if (sh_ack) begin
                    if (st_q.cnt == CNT_W'(st_q.plan.n_dummy - 5'd1)) begin
                        st_d.phase = PH_DATA;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (sh_ack) begin
                    if (!st_q.we) begin
                        st_d.rdata[{st_q.cnt[SZ_W-1:0], 3'b000} +: 8] = sh_rx;
                    end
                    if (st_q.cnt[SZ_W-1:0] == st_q.last) begin
                        st_d.phase = PH_DONE;
                        st_d.cs    = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_DONE: st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n      = ~st_q.cs;
    assign sh_req    = (st_q.phase == PH_CMD) || (st_q.phase == PH_ADDR) ||
                       (st_q.phase == PH_DUMMY) || (st_q.phase == PH_DATA);
    assign bus_ready = (st_q.phase == PH_DONE);
    assign bus_err   = (st_q.phase == PH_DONE) && st_q.err;
    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/fws_chk.sv
module fws_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ready,
    input logic              sh_req,
    input logic [NUM_CS-1:0] cs_n,
    input logic [2:0]        phase
);
    // R2
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2
    req_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_req |-> !(&cs_n));

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && bus_req) |=> sh_req);

    // R9
    ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> ((&cs_n) && !sh_req));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0) |-> ((&cs_n) && !sh_req && !bus_ready));
endmodule

bind flash_window_seq fws_chk #(.NUM_CS(NUM_CS)) u_fws_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ready (bus_ready),
    .sh_req    (sh_req),
    .cs_n      (cs_n),
    .phase     (st_q.phase)
);

// File: tb/flash_window_seq_test.sv
`timescale 1ns/1ps
module flash_window_seq_test;
    localparam int NUM_CS = 2;
    localparam int WIN_AW = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [0:0]  bus_cs_sel = '0;
    logic [26:0] bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_ready, bus_err;
    logic [31:0] rd_cfg = '0;
    logic [31:0] wr_cfg = '0;
    logic        uma_cs_busy = 1'b0;
    logic [1:0]  cs_n;
    logic        sh_req;
    logic [7:0]  sh_tx;
    logic        sh_ack = 1'b0;
    logic [7:0]  sh_rx = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0] tx_log [64];
    logic [1:0] cs_log [64];
    int         n_log = 0;

    logic [7:0] exp_tx [64];
    int         n_exp;

    always #5 clk = ~clk;

    flash_window_seq #(.NUM_CS(NUM_CS), .WIN_AW(WIN_AW), .MAX_BYTES(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_cs_sel(bus_cs_sel), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .rd_cfg(rd_cfg), .wr_cfg(wr_cfg),
        .uma_cs_busy(uma_cs_busy), .cs_n(cs_n), .sh_req(sh_req),
        .sh_tx(sh_tx), .sh_ack(sh_ack), .sh_rx(sh_rx)
    );

    // shifter model: answers each request; received byte = 0x30 + frame index
    initial begin
        forever begin
            @(negedge clk);
            if (sh_ack) begin
                sh_ack = 1'b0;
            end else if (sh_req) begin
                if (n_log < 64) begin
                    tx_log[n_log] = sh_tx;
                    cs_log[n_log] = cs_n;
                end
                sh_rx  = 8'h30 + 8'(n_log);
                n_log  = n_log + 1;
                sh_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: run did not finish act 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act %h exp %h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input logic [7:0] cmd, input logic [1:0] alen,
                                          input logic [1:0] dbw, input logic [1:0] acc);
        return {14'b0, alen, 2'b0, dbw, 2'b0, acc, cmd};
    endfunction

    // build the expected frame from the requirements; returns expected rdata
    task automatic build_exp(input logic we, input logic [31:0] cfg, input logic [26:0] addr,
                             input int nbytes, input logic [63:0] wd,
                             output logic [63:0] exp_rd);
        int na, nd;
        logic [31:0] a32;
        a32 = {5'b0, addr};
        na = (cfg[17:16] == 2'd0) ? 3 : (cfg[17:16] == 2'd1) ? 4 : 0;
        nd = we ? 0 : ((int'(cfg[13:12]) * 8) >> cfg[9:8]);
        n_exp = 0;
        exp_tx[n_exp++] = cfg[7:0];
        for (int i = na - 1; i >= 0; i--) exp_tx[n_exp++] = a32[i*8 +: 8];
        for (int i = 0; i < nd; i++) exp_tx[n_exp++] = 8'h00;
        exp_rd = '0;
        for (int i = 0; i < nbytes; i++) begin
            exp_tx[n_exp] = we ? wd[i*8 +: 8] : 8'h00;
            if (!we) exp_rd[i*8 +: 8] = 8'h30 + 8'(n_exp);
            n_exp = n_exp + 1;
        end
    endtask

    task automatic run_access(input string tag, input logic we, input logic cs,
                              input logic [26:0] addr, input int nbytes,
                              input logic [63:0] wd, input logic busy);
        logic [63:0] exp_rd;
        logic [1:0]  exp_cs;
        int          waitc;
        build_exp(we, we ? wr_cfg : rd_cfg, addr, nbytes, wd, exp_rd);
        exp_cs = ~(2'b01 << cs);
        @(negedge clk);
        n_log       = 0;
        bus_we      = we;
        bus_cs_sel  = cs;
        bus_addr    = addr;
        bus_size    = 3'(nbytes - 1);
        bus_wdata   = wd;
        uma_cs_busy = busy;
        bus_req     = 1'b1;
        waitc = 0;
        @(negedge clk);
        while (!bus_ready && waitc < 300) begin
            @(negedge clk);
            waitc = waitc + 1;
        end
        chk(bus_ready, {tag, " R9 ready seen"}, 64'(bus_ready), 64'd1);
        chk(&cs_n, {tag, " R9 cs released at ready"}, 64'(cs_n), 64'h3);
        chk(bus_err == busy, {tag, " R10 err flag"}, 64'(bus_err), 64'(busy));
        if (!we) chk(bus_rdata == exp_rd, {tag, " R7 read data"}, bus_rdata, exp_rd);
        bus_req     = 1'b0;
        uma_cs_busy = 1'b0;
        chk(n_log == n_exp, {tag, " R6 transfer count"}, 64'(n_log), 64'(n_exp));
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            chk(tx_log[i] == exp_tx[i], $sformatf("%s R4 byte %0d", tag, i),
                64'(tx_log[i]), 64'(exp_tx[i]));
            chk(cs_log[i] == exp_cs, $sformatf("%s R2 cs at byte %0d", tag, i),
                64'(cs_log[i]), 64'(exp_cs));
        end
        @(negedge clk);
        chk(!bus_ready, {tag, " R9 single pulse"}, 64'(bus_ready), 64'd0);
        chk(&cs_n && !sh_req, {tag, " R1 quiet after"}, {62'b0, cs_n}, 64'h3);
    endtask

    task automatic t_reset();
        chk(&cs_n, "R1 cs after reset", 64'(cs_n), 64'h3);
        chk(!sh_req, "R1 req after reset", 64'(sh_req), 64'd0);
        chk(!bus_ready, "R1 ready after reset", 64'(bus_ready), 64'd0);
    endtask

    task automatic t_read_three();   // R3 R4 R6 R7: 3-byte address, 8 dummies
        rd_cfg = mk_cfg(8'h0B, 2'd0, 2'd1, 2'd0);
        wr_cfg = mk_cfg(8'h02, 2'd0, 2'd3, 2'd0);
        run_access("R3 read3", 1'b0, 1'b0, 27'h1234567, 4, 64'h0, 1'b0);
    endtask

    task automatic t_read_four();    // R4 R6: 4-byte address, 24>>2 = 6 dummies, 8 bytes
        rd_cfg = mk_cfg(8'hEC, 2'd1, 2'd3, 2'd2);
        run_access("R4 read4", 1'b0, 1'b1, 27'h7FFFFFF, 8, 64'h0, 1'b0);
    endtask

    task automatic t_read_noaddr();  // R5 R7: no address, no dummy, 1 byte, upper lanes zero
        rd_cfg = mk_cfg(8'h9F, 2'd2, 2'd0, 2'd0);
        run_access("R5 noaddr", 1'b0, 1'b0, 27'h0000123, 1, 64'h0, 1'b0);
        rd_cfg = mk_cfg(8'h9E, 2'd3, 2'd2, 2'd3);
        run_access("R5 code3", 1'b0, 1'b1, 27'h0000001, 3, 64'h0, 1'b0);
    endtask

    task automatic t_write();        // R3 R8: write ignores dummy fields
        run_access("R8 write3", 1'b1, 1'b1, 27'h0ABCDEF, 3, 64'h1122334455667788, 1'b0);
        wr_cfg = mk_cfg(8'h12, 2'd1, 2'd1, 2'd0);
        run_access("R8 write8", 1'b1, 1'b0, 27'h4000003, 8, 64'hF0E1D2C3B4A59687, 1'b0);
    endtask

    task automatic t_conflict();     // R10
        run_access("R10 busy", 1'b0, 1'b1, 27'h0000040, 2, 64'h0, 1'b1);
        run_access("R10 clear", 1'b1, 1'b0, 27'h0000041, 2, 64'hBEEF, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_read_three();
        t_read_four();
        t_read_noaddr();
        t_write();
        t_conflict();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule